// File: doc/BRIEF.md
# PCM Bit-Clock Rate Detector

This block finds out which of eleven supported PCM bit-clock rates is driving the serial highway. It counts bit-clock strobes between consecutive 8 kHz frame-sync pulses, looks the count up in a fixed rate table, and reports a 4-bit clock code together with a lock flag. The analog clock multiplier that would follow it is represented only by the lock flag. Both inputs arrive as single-cycle strobes that have already been synchronised to the system clock.

A small write port holds a programmed clock code and a master-mode bit. When the programmed code is zero and the device is in slave mode, the block detects the rate by itself and reports the code it found. When a nonzero code is programmed, the block reports that code and raises lock only while the measured clock matches it. A nonzero code can only be loaded over a zero code. Setting and then clearing the master bit with a zero code starts detection again from the beginning.

Top module: `pcm_clk_detect`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `code_o` is 0, `lock_o` is 0, the programmed code is 0 and the master bit is 0, which is slave mode.
- R2: A frame count is the number of cycles with `bclk_tick` high after one `fsync` cycle, up to and including the next `fsync` cycle. Only an exact count maps to a code: 32→1, 64→2, 96→3, 128→4, 192→5, 193→6, 256→7, 386→8, 512→9, 772→10, 1024→11. Every other count maps to no code.
- R3: In auto mode (slave, programmed code 0), the first `fsync` after a restart only starts a frame. `lock_o` rises, and `code_o` shows the detected code, at the clock edge that closes the second consecutive frame mapping to the same code.
- R4: In auto mode, a frame whose code differs from the previous frame's clears `lock_o`, and `code_o` returns to 0 at the edge that closes that frame.
- R5: A count that maps to no code never produces lock.
- R6: A write with `wr_code` = 0 always sets the programmed code to 0. A nonzero `wr_code` is loaded only when the programmed code is 0. A nonzero write over a nonzero code leaves the code unchanged. `wr_master` is always loaded.
- R7: With a nonzero programmed code, `code_o` equals that code. `lock_o` rises only after two consecutive frames whose count maps to that code, and it falls on the first frame that does not.
- R8: In master mode with programmed code 0, detection is idle: `lock_o` stays 0 and `code_o` stays 0 whatever frames arrive.
- R9: A write that changes the master bit or the programmed code restarts measurement. `lock_o` is 0 from the next edge, and the next `fsync` only starts a frame.
- R10: The in-frame counter saturates at 2^CNT_W−1 and never wraps. For example, 2080 strobes in a frame do not map to code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_tick | input | 1 | One-cycle strobe per bit-clock period |
| fsync | input | 1 | One-cycle strobe per 8 kHz frame |
| wr_en | input | 1 | Write strobe for the configuration fields |
| wr_master | input | 1 | Master-mode bit to write |
| wr_code | input | 4 | Clock code to write |
| code_o | output | 4 | Programmed code if nonzero, otherwise the detected code |
| lock_o | output | 1 | Lock indication |

## Verification
The bench builds the block with the default counter width of 11 bits, which leaves room for the 1024-strobe frame and places saturation at 2047. That limit can be reached with a single 2100-cycle frame, so the wrap case (2080 strobes aliasing to 32) is tested directly. Frames of 1100 cycles carry every table rate. This includes the adjacent 192 and 193 counts, so exact matching is exercised at its tightest spacing.

// File: rtl/pcm_clk_pkg.sv
// Package: shared constants and the rate table for the PCM bit-clock detector.
// Assumes a 125 us frame, so each code's count equals bit-clock rate / 8 kHz.
package pcm_clk_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_RATES = 11;

    // Expected strobes per frame for a clock code; 0 for unused codes.
    function automatic int rate_count(input int code);
        case (code)
            1:       return 32;
            2:       return 64;
            3:       return 96;
            4:       return 128;
            5:       return 192;
            6:       return 193;
            7:       return 256;
            8:       return 386;
            9:       return 512;
            10:      return 772;
            11:      return 1024;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pcm_cfg_regs.sv
// Module: configuration fields (master bit, programmed clock code).
// Applies the code-change rule: zero is always accepted, and a nonzero code
// only replaces zero. Flags a restart whenever a write changes either field.
// Assumes wr_* are synchronous to clk.
module pcm_cfg_regs
    import pcm_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_master,
    input  logic [CODE_W-1:0] wr_code,
    output logic              master_q,
    output logic [CODE_W-1:0] code_q,
    output logic              restart
);

    logic [CODE_W-1:0] code_next;

    // Decide which code a write would leave in place.
    always_comb begin
        if (wr_code == '0 || code_q == '0)
            code_next = wr_code;
        else
            code_next = code_q;
    end

    // A write that alters either field restarts measurement.
    always_comb begin
        restart = wr_en && ((wr_master != master_q) || (code_next != code_q));
    end

    // Hold the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            code_q   <= '0;
        end else if (wr_en) begin
            master_q <= wr_master;
            code_q   <= code_next;
        end
    end

    AST_NZ_OVER_NZ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code_q != '0 && wr_code != '0) |=> $stable(code_q)); // R6
    AST_ZERO_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == '0) |=> (code_q == '0)); // R6

endmodule

// File: rtl/pcm_frame_counter.sv
// Module: counts bit-clock strobes inside one frame and presents the finished
// frame total on the fsync cycle. The first fsync after a clear only arms.
// Assumes bclk_tick and fsync are single-cycle strobes synchronous to clk.
module pcm_frame_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bclk_tick,
    input  logic             fsync,
    output logic [CNT_W-1:0] frame_total,
    output logic             frame_valid
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Saturating sum of the running count and this cycle's strobe.
    always_comb begin
        if (cnt_q == CNT_MAX)
            frame_total = CNT_MAX;
        else
            frame_total = cnt_q + CNT_W'(bclk_tick);
    end

    // A total is usable only when a full frame was observed since the clear.
    always_comb begin
        frame_valid = fsync && armed_q && !clear;
    end

    // Running count and arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (fsync) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            cnt_q   <= frame_total;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !fsync && !clear) |=> (cnt_q == CNT_MAX)); // R10
    AST_FIRST_SYNC_ARMS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !frame_valid || armed_q); // R9

endmodule

// File: rtl/pcm_rate_match.sv
// Module: maps a frame total to a clock code by exact comparison against
// every table entry. Yields 0 when no entry matches.
// Assumes the table counts are distinct, so at most one entry hits.
module pcm_rate_match
    import pcm_clk_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0]  frame_total,
    output logic [CODE_W-1:0] match_code
);

    logic [NUM_RATES-1:0] hit;

    // One comparator per supported rate.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
        assign hit[g] = (frame_total == CNT_W'(rate_count(g + 1)));
    end

    // Encode the hit into its code.
    always_comb begin
        match_code = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (hit[i])
                match_code = CODE_W'(i + 1);
        end
    end

endmodule

// File: rtl/pcm_lock_tracker.sv
// Module: confirms a rate over two consecutive frames and drives the lock flag
// and the detected code. With a manual code, only that code can lock.
// Assumes frame_valid and clear are never high together.
module pcm_lock_tracker
    import pcm_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              frame_valid,
    input  logic [CODE_W-1:0] match_code,
    input  logic [CODE_W-1:0] manual_code,
    output logic              lock_q,
    output logic [CODE_W-1:0] det_q
);

    logic [CODE_W-1:0] prev_q;
    logic              lock_next;

    // Lock needs a real match that repeats and agrees with any manual code.
    always_comb begin
        lock_next = (match_code != '0) && (match_code == prev_q) &&
                    ((manual_code == '0) || (match_code == manual_code));
    end

    // Per-frame history, lock flag and detected code.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_q <= '0;
            lock_q <= 1'b0;
            det_q  <= '0;
        end else if (frame_valid) begin
            prev_q <= match_code;
            lock_q <= lock_next;
            det_q  <= lock_next ? match_code : '0;
        end
    end

    AST_CHANGE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && match_code != prev_q) |=> !lock_q); // R4
    AST_NO_MATCH_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && match_code == '0) |=> !lock_q); // R5
    AST_MANUAL_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && manual_code != '0 && match_code != manual_code) |=> !lock_q); // R7

endmodule

// File: rtl/pcm_clk_detect.sv
// Module (top): PCM bit-clock rate detector. Combines the configuration
// fields, the frame counter, the rate table and the lock tracker.
// Assumes bclk_tick/fsync are pre-synchronised single-cycle strobes and
// at most one bit-clock strobe arrives per system clock.
module pcm_clk_detect
    import pcm_clk_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_tick,
    input  logic              fsync,
    input  logic              wr_en,
    input  logic              wr_master,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_o,
    output logic              lock_o
);

    logic              master_q;
    logic [CODE_W-1:0] code_q;
    logic              restart;
    logic              clear;
    logic [CNT_W-1:0]  frame_total;
    logic              frame_valid;
    logic [CODE_W-1:0] match_code;
    logic              lock_q;
    logic [CODE_W-1:0] det_q;

    pcm_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_master (wr_master),
        .wr_code   (wr_code),
        .master_q  (master_q),
        .code_q    (code_q),
        .restart   (restart)
    );

    // Measurement is held cleared on a restart or while idle in master mode.
    always_comb begin
        clear = restart || (master_q && code_q == '0);
    end

    pcm_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .bclk_tick   (bclk_tick),
        .fsync       (fsync),
        .frame_total (frame_total),
        .frame_valid (frame_valid)
    );

    pcm_rate_match #(.CNT_W(CNT_W)) u_match (
        .frame_total (frame_total),
        .match_code  (match_code)
    );

    pcm_lock_tracker u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .frame_valid (frame_valid),
        .match_code  (match_code),
        .manual_code (code_q),
        .lock_q      (lock_q),
        .det_q       (det_q)
    );

    // Report the programmed code when set, otherwise the detected one.
    always_comb begin
        code_o = (code_q != '0) ? code_q : det_q;
        lock_o = lock_q;
    end

    AST_IDLE_IN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (master_q && code_q == '0) |-> (!lock_o && code_o == '0)); // R8
    AST_RESTART_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !lock_o); // R9

endmodule

// File: tb/tb_pcm_clk_detect.sv
module tb_pcm_clk_detect;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 11;
    localparam int CNT_MAX    = (1 << CNT_W) - 1;
    localparam int FRAME_LEN  = 1100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_tick = 1'b0;
    logic       fsync = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_master = 1'b0;
    logic [3:0] wr_code = 4'd0;
    logic [3:0] code_o;
    logic       lock_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    int rate_tab [11] = '{32, 64, 96, 128, 192, 193, 256, 386, 512, 772, 1024};

    // reference model state
    int m_master, m_code, m_cnt, m_armed, m_prev, m_lock, m_det;

    pcm_clk_detect #(.CNT_W(CNT_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_tick (bclk_tick),
        .fsync     (fsync),
        .wr_en     (wr_en),
        .wr_master (wr_master),
        .wr_code   (wr_code),
        .code_o    (code_o),
        .lock_o    (lock_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int rate_of(int n);
        for (int i = 0; i < 11; i++)
            if (rate_tab[i] == n) return i + 1;
        return 0;
    endfunction

    // Behavioural reference model, advanced on every clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_master = 0; m_code = 0; m_cnt = 0; m_armed = 0;
            m_prev = 0; m_lock = 0; m_det = 0;
        end else begin
            int nm, nc, tot, mc, lk;
            bit rs, idle;
            rs = 0;
            nm = m_master;
            nc = m_code;
            if (wr_en) begin
                nm = wr_master;
                nc = (wr_code == 0 || m_code == 0) ? int'(wr_code) : m_code;
                rs = (nm != m_master) || (nc != m_code);
            end
            idle = (m_master != 0) && (m_code == 0);
            if (rs || idle) begin
                m_cnt = 0; m_armed = 0; m_prev = 0; m_lock = 0; m_det = 0;
            end else begin
                tot = m_cnt + int'(bclk_tick);
                if (tot > CNT_MAX) tot = CNT_MAX;
                if (fsync) begin
                    if (m_armed != 0) begin
                        mc = rate_of(tot);
                        lk = (mc != 0 && mc == m_prev && (m_code == 0 || mc == m_code)) ? 1 : 0;
                        m_lock = lk;
                        m_det = lk ? mc : 0;
                        m_prev = mc;
                    end
                    m_armed = 1;
                    m_cnt = 0;
                end else begin
                    m_cnt = tot;
                end
            end
            m_master = nm;
            m_code = nc;
        end
    end

    // Compare outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            int ec;
            ec = (m_code != 0) ? m_code : m_det;
            checks++;
            if (int'(code_o) != ec || int'(lock_o) != m_lock) begin
                failures++;
                $display("FAIL %s model compare: actual code=%0d lock=%0d expected code=%0d lock=%0d",
                         cur_req, code_o, lock_o, ec, m_lock);
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycle(bit t, bit f);
        bclk_tick = t;
        fsync = f;
        @(posedge clk);
        #1;
        bclk_tick = 1'b0;
        fsync = 1'b0;
    endtask

    task automatic frame(int k, int len);
        for (int i = 0; i < len; i++)
            cycle(i < k, i == len - 1);
    endtask

    task automatic wr(bit m, int c);
        wr_en = 1'b1;
        wr_master = m;
        wr_code = 4'(c);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic restart_auto();
        wr(1'b1, 0);
        wr(1'b0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cur_req = "R1";
        chk("R1", "code after reset", code_o, 0);
        chk("R1", "lock after reset", lock_o, 0);

        // R2/R3: every table rate detected automatically
        for (int i = 0; i < 11; i++) begin
            cur_req = "R3";
            restart_auto();
            frame(rate_tab[i], FRAME_LEN);
            frame(rate_tab[i], FRAME_LEN);
            chk("R3", "no lock after one measured frame", lock_o, 0);
            frame(rate_tab[i], FRAME_LEN);
            chk("R2", "lock on table rate", lock_o, 1);
            chk("R3", "detected code", code_o, i + 1);
        end

        // R4: rate change drops lock, then re-locks
        cur_req = "R4";
        frame(256, FRAME_LEN);
        chk("R4", "lock after rate change", lock_o, 0);
        chk("R4", "code after rate change", code_o, 0);
        frame(256, FRAME_LEN);
        chk("R4", "relock code", code_o, 7);

        // R2: strobe in the fsync cycle belongs to the closing frame
        cur_req = "R2";
        restart_auto();
        frame(32, 32);
        frame(32, 32);
        frame(32, 32);
        chk("R2", "fsync-cycle strobe counted", code_o, 1);

        // R5: unsupported count
        cur_req = "R5";
        restart_auto();
        repeat (3) frame(100, FRAME_LEN);
        chk("R5", "lock on unsupported count", lock_o, 0);
        chk("R5", "code on unsupported count", code_o, 0);

        // R10: saturation, no wrap onto code 1
        cur_req = "R10";
        restart_auto();
        repeat (3) frame(2080, 2100);
        chk("R10", "lock after overflow frames", lock_o, 0);

        // R8: master mode idle
        cur_req = "R8";
        wr(1'b1, 0);
        repeat (3) frame(256, FRAME_LEN);
        chk("R8", "lock in master idle", lock_o, 0);
        chk("R8", "code in master idle", code_o, 0);
        wr(1'b0, 0);

        // R6: code write rule
        cur_req = "R6";
        wr(1'b0, 5);
        chk("R6", "load over zero", code_o, 5);
        wr(1'b0, 7);
        chk("R6", "nonzero over nonzero ignored", code_o, 5);
        wr(1'b0, 0);
        chk("R6", "zero accepted", code_o, 0);
        wr(1'b0, 7);
        chk("R6", "load after zero", code_o, 7);

        // R7: manual code
        cur_req = "R7";
        repeat (3) frame(256, FRAME_LEN);
        chk("R7", "manual lock", lock_o, 1);
        chk("R7", "manual code shown", code_o, 7);
        frame(512, FRAME_LEN);
        chk("R7", "manual mismatch drops lock", lock_o, 0);
        frame(512, FRAME_LEN);
        chk("R7", "other rate never locks manual", lock_o, 0);
        chk("R7", "manual code kept", code_o, 7);
        wr(1'b0, 0);

        // R9: master toggle restarts detection
        cur_req = "R9";
        repeat (3) frame(64, FRAME_LEN);
        chk("R9", "locked before toggle", lock_o, 1);
        wr(1'b1, 0);
        chk("R9", "lock cleared by write", lock_o, 0);
        wr(1'b0, 0);
        frame(64, FRAME_LEN);
        frame(64, FRAME_LEN);
        chk("R9", "no lock one frame after restart", lock_o, 0);
        frame(64, FRAME_LEN);
        chk("R9", "relock after restart", code_o, 2);

        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule